// File: doc/BRIEF.md
# Link-On Wake Notification Generator

This block drives the wake notification pin of a physical-layer device toward its link-layer controller. While the controller is asleep, a qualifying event makes the pin oscillate as a square wave. Power-up logic on the controller side sees the toggling and wakes the controller. Once the controller reports itself fully active, the pin goes quiet again.

Two conditions start the oscillation, and either is enough: a link-on packet addressed to this node, or a pending physical-layer interrupt. Either one counts only while the controller is inactive. The controller is inactive when its power-status level is low or its link-control bit is 0.

A bus reset normally cancels the oscillation. The one exception is a pending interrupt, which keeps the oscillation running. The oscillation period comes from a parameter. With a 49.152 MHz clock and the default half period of four cycles, the period is eight cycles, which is about 163 ns.

Top module: `linkon_wake_gen`

## Requirements
- R1: A synchronous active-high reset clears the pending wake request and forces `linkon_o` low. The output stays low until a new wake event arrives.
- R2: The controller counts as active only when `lps_i` is 1 and `lctrl_i` is 1. If either one is 0, an oscillation in progress keeps running.
- R3: A wake event is `pkt_linkon_i` = 1 or `phy_irq_i` = 1. An event starts the oscillation only while the controller is inactive. An event while the controller is active leaves `linkon_o` low.
- R4: While running, `linkon_o` is a square wave that stays HALF_CYCLES clock cycles in each level, so one period is 2*HALF_CYCLES cycles.
- R5: Each oscillation starts in its low phase. After the clock edge that accepts the event, `linkon_o` stays low for HALF_CYCLES cycles and then rises.
- R6: When the controller is sampled active, the request clears and `linkon_o` is low from that clock edge onward.
- R7: When `bus_rst_i` = 1 is sampled with `phy_irq_i` = 0, the request clears and `linkon_o` is low from that edge onward.
- R8: When `bus_rst_i` = 1 is sampled with `phy_irq_i` = 1 while the controller is inactive, the oscillation continues without a break in its phase.
- R9: If a clear condition and a start condition occur in the same cycle, the clear wins. For example, `pkt_linkon_i` together with `bus_rst_i` and no pending interrupt leaves `linkon_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lps_i | input | 1 | Controller power-status level, 1 = powered |
| lctrl_i | input | 1 | Link-control register bit, 1 = controller enabled |
| pkt_linkon_i | input | 1 | One-cycle strobe: link-on packet for this node received |
| phy_irq_i | input | 1 | Physical-layer interrupt pending level |
| bus_rst_i | input | 1 | One-cycle strobe: bus reset seen |
| linkon_o | output | 1 | Wake notification square wave, low when idle |

## Verification
On every cycle, the checker enforces the start, stop and priority rules on the internal request. It also checks that the output is low after a reset, after activity or after a plain bus reset, that each run begins in its low phase, and that every edge of the output falls exactly HALF_CYCLES cycles after the previous one.

Some behaviour only the bench scenarios can show. These include the exact phase of the waveform over long runs, a bus reset with a pending interrupt that leaves the phase untouched, and the way the rules combine under random mixes of strobes and levels.

// File: rtl/linkon_pkg.sv
package linkon_pkg;

    // Sampled inputs of one cycle.
    typedef struct packed {
        logic lps;
        logic lctrl;
        logic pkt;
        logic irq;
        logic bus_rst;
    } wake_in_t;

    // Decision for the wake request register.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SET   = 2'd1,
        ACT_CLEAR = 2'd2
    } req_act_t;

    // Controller counts as active only with both indications set.
    function automatic logic link_is_active(input wake_in_t s);
        return s.lps & s.lctrl;
    endfunction

    function automatic logic wake_event(input wake_in_t s);
        return s.pkt | s.irq;
    endfunction

    // Clear has priority over set.
    function automatic req_act_t decide(input wake_in_t s);
        logic clr;
        logic set;
        clr = link_is_active(s) | (s.bus_rst & ~s.irq);
        set = wake_event(s) & ~link_is_active(s);
        if (clr)      return ACT_CLEAR;
        else if (set) return ACT_SET;
        else          return ACT_HOLD;
    endfunction

endpackage

// File: rtl/linkon_decode.sv
module linkon_decode
    import linkon_pkg::*;
(
    input  wake_in_t in_s,
    output req_act_t act
);
    always_comb begin
        act = decide(in_s);
    end
endmodule

// File: rtl/linkon_req_reg.sv
module linkon_req_reg
    import linkon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  req_act_t act,
    output logic     req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_CLEAR: req_q <= 1'b0;
                ACT_SET:   req_q <= 1'b1;
                default:   req_q <= req_q;
            endcase
        end
    end
endmodule

// File: rtl/linkon_osc.sv
module linkon_osc #(
    parameter int HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic phase
);
    generate
        if (HALF_CYCLES <= 1) begin : g_fast
            // Toggle every cycle; first cycle of a run is low.
            always_ff @(posedge clk) begin
                if (rst || !run) phase <= 1'b0;
                else             phase <= ~phase;
            end
        end else begin : g_div
            localparam int CW = $clog2(HALF_CYCLES);
            localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt_q <= '0;
                    phase <= 1'b0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    phase <= ~phase;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/linkon_wake_gen.sv
module linkon_wake_gen
    import linkon_pkg::*;
#(
    parameter int HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lps_i,
    input  logic lctrl_i,
    input  logic pkt_linkon_i,
    input  logic phy_irq_i,
    input  logic bus_rst_i,
    output logic linkon_o
);
    wake_in_t in_s;
    req_act_t act;
    logic     req_q;
    logic     phase;

    always_comb begin
        in_s.lps     = lps_i;
        in_s.lctrl   = lctrl_i;
        in_s.pkt     = pkt_linkon_i;
        in_s.irq     = phy_irq_i;
        in_s.bus_rst = bus_rst_i;
    end

    linkon_decode u_decode (
        .in_s (in_s),
        .act  (act)
    );

    linkon_req_reg u_req (
        .clk   (clk),
        .rst   (rst),
        .act   (act),
        .req_q (req_q)
    );

    linkon_osc #(.HALF_CYCLES(HALF_CYCLES)) u_osc (
        .clk   (clk),
        .rst   (rst),
        .run   (req_q),
        .phase (phase)
    );

    // Masked so the pin drops in the same edge the request clears.
    assign linkon_o = phase & req_q;
endmodule

// File: rtl/linkon_wake_chk.sv
module linkon_wake_chk #(
    parameter int HALF_CYCLES = 4
) (
    input logic clk,
    input logic rst,
    input logic lps_i,
    input logic lctrl_i,
    input logic pkt_linkon_i,
    input logic phy_irq_i,
    input logic bus_rst_i,
    input logic req_q,
    input logic linkon_o
);
    localparam int HW = $clog2(HALF_CYCLES + 2) + 1;

    logic          prev_o;
    logic [HW-1:0] hold;

    // Cycles the output has kept its level during a run.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_o <= 1'b0;
            hold   <= '0;
        end else begin
            prev_o <= linkon_o;
            if (!req_q)                hold <= '0;
            else if (linkon_o != prev_o) hold <= HW'(1);
            else if (hold != '1)       hold <= hold + 1'b1;
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk) rst |=> !linkon_o && !req_q); // R1
    AST_ONE_LOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (req_q && !(lps_i && lctrl_i) && !bus_rst_i) |=> req_q); // R2
    AST_NO_START: assert property (@(posedge clk) disable iff (rst)
        (!req_q && !((pkt_linkon_i || phy_irq_i) && !(lps_i && lctrl_i))) |=> !req_q); // R3
    AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (req_q && (linkon_o != prev_o)) |-> (hold == HW'(HALF_CYCLES))); // R4
    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        (!req_q && !rst) |=> !linkon_o); // R5
    AST_ACTIVE_STOP: assert property (@(posedge clk) disable iff (rst)
        (lps_i && lctrl_i) |=> !linkon_o && !req_q); // R6
    AST_BUSRST_STOP: assert property (@(posedge clk) disable iff (rst)
        (bus_rst_i && !phy_irq_i) |=> !linkon_o && !req_q); // R7
    AST_BUSRST_IRQ_KEEP: assert property (@(posedge clk) disable iff (rst)
        (bus_rst_i && phy_irq_i && req_q && !(lps_i && lctrl_i)) |=> req_q); // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (pkt_linkon_i && bus_rst_i && !phy_irq_i && !req_q) |=> !req_q); // R9
endmodule

bind linkon_wake_gen linkon_wake_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .lps_i        (lps_i),
    .lctrl_i      (lctrl_i),
    .pkt_linkon_i (pkt_linkon_i),
    .phy_irq_i    (phy_irq_i),
    .bus_rst_i    (bus_rst_i),
    .req_q        (req_q),
    .linkon_o     (linkon_o)
);

// File: tb/test_linkon_wake_gen.sv
module test_linkon_wake_gen;
    localparam int CLK_PERIOD = 20;
    localparam int HALF_CYC   = 4;
    localparam int MAX_CYC    = 200000;

    logic clk = 1'b0;
    logic rst, lps, lctrl, pkt, irq, bus;
    logic linkon_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    // Reference state, updated from the requirements.
    bit req_m = 0;
    int age_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    linkon_wake_gen #(.HALF_CYCLES(HALF_CYC)) i_linkon_wake_gen (
        .clk(clk), .rst(rst), .lps_i(lps), .lctrl_i(lctrl),
        .pkt_linkon_i(pkt), .phy_irq_i(irq), .bus_rst_i(bus),
        .linkon_o(linkon_o)
    );

    function automatic bit exp_out(bit r, int age);
        return r && (((age / HALF_CYC) % 2) == 1);
    endfunction

    task automatic chk(string tag);
        bit e;
        e = exp_out(req_m, age_m);
        n_chk++;
        if (linkon_o !== e) begin
            n_fail++;
            $display("FAIL %s cycle %0d: linkon_o=%0b expected %0b", tag, cyc, linkon_o, e);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, check at the next one.
    task automatic step(bit r, bit lp, bit lc, bit pk, bit iq, bit br, string tag);
        bit act, nreq;
        int nage;
        rst = r; lps = lp; lctrl = lc; pkt = pk; irq = iq; bus = br;
        act  = lp && lc;
        nreq = req_m;
        nage = age_m + 1;
        if (r || act || (br && !iq)) begin
            nreq = 0; nage = 0;
        end else if ((pk || iq) && !req_m) begin
            nreq = 1; nage = 0;
        end
        @(negedge clk);
        req_m = nreq;
        age_m = nreq ? nage : 0;
        chk(tag);
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYC);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        string tag;
        void'($urandom(32'd2024));
        rst = 1; lps = 0; lctrl = 0; pkt = 0; irq = 0; bus = 0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R1");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, "R1");

        // Interrupt while controller disabled: low phase then square wave.
        step(0, 1, 0, 0, 1, 0, "R3");
        for (int i = 0; i < HALF_CYC - 1; i++) step(0, 1, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 4 * HALF_CYC; i++) step(0, 1, 0, 0, 0, 0, "R4");
        // Controller becomes active: stop.
        for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 0, 0, "R6");
        // Packet while active: ignored.
        step(0, 1, 1, 1, 0, 0, "R3");
        for (int i = 0; i < 2 * HALF_CYC; i++) step(0, 1, 1, 0, 0, 0, "R3");

        // Power status low with control bit set: still inactive.
        step(0, 0, 1, 1, 0, 0, "R2");
        for (int i = 0; i < 3 * HALF_CYC; i++) step(0, 0, 1, 0, 0, 0, "R2");
        // Bus reset without interrupt stops it.
        step(0, 0, 1, 0, 0, 1, "R7");
        for (int i = 0; i < 2 * HALF_CYC; i++) step(0, 0, 1, 0, 0, 0, "R7");

        // Bus reset with pending interrupt keeps phase.
        step(0, 0, 0, 0, 1, 0, "R8");
        for (int i = 0; i < HALF_CYC + 1; i++) step(0, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 1, 1, "R8");
        for (int i = 0; i < 3 * HALF_CYC; i++) step(0, 0, 0, 0, 1, 0, "R8");
        // Reset during oscillation.
        step(1, 0, 0, 0, 1, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 1, "R7");

        // Packet and bus reset together: clear wins.
        step(0, 0, 0, 1, 0, 1, "R9");
        for (int i = 0; i < 2 * HALF_CYC; i++) step(0, 0, 0, 0, 0, 0, "R9");

        // Constrained random mix.
        for (int i = 0; i < 5000; i++) begin
            bit r, lp, lc, pk, iq, br;
            r  = ($urandom % 500) == 0;
            lp = ($urandom % 8) != 0;
            lc = ($urandom % 6) == 0;
            pk = ($urandom % 20) == 0;
            iq = ($urandom % 30) == 0;
            br = ($urandom % 40) == 0;
            if (r)                    tag = "R1";
            else if (lp && lc)        tag = "R6";
            else if (br && !iq)       tag = "R7";
            else if (br && iq)        tag = "R8";
            else if (req_m)           tag = "R4";
            else                      tag = "R3";
            step(r, lp, lc, pk, iq, br, tag);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule